// File: doc/BRIEF.md
# Video Line Packet Buffer with Auto-Advancing Read Port

The block stores received video data lines in a byte-wide RAM split into fixed-size rows. Row 0 is kept back for control information and is never written or read here. The remaining rows form a circular packet region. A line arrives as a byte stream. The byte that carries the start strobe is the first of two info bytes: the first gives the line and field number, the second the data type. The payload follows them. For teletext the payload is two address bytes and forty data bytes; other formats use the same row layout. A line is committed once a full row of bytes has been taken. A line that starts while every packet row holds unread data is dropped whole, and a saturating counter records it.

The host reads from a single 8-bit port. Each accepted read returns the next stored byte one cycle later. An internal pointer walks the row and then moves on to the following row. Three packet-granular commands move the pointer: restart at the first packet row, rewind to byte 0 of the current packet, or skip to byte 0 of the next packet. The number of committed, unconsumed packets is exported so that interrupt and DMA logic can act on it.

Top module: `vbi_pkt_buf`

## Requirements
- R1: After reset, `pkt_count_o` is 0, `drop_count_o` is 0 and `rd_data_o` is 0x00.
- R2: A line is the byte with `wr_valid_i`=1 and `wr_start_i`=1, followed by ROW_BYTES-1 further bytes with `wr_valid_i`=1 and `wr_start_i`=0. `pkt_count_o` rises by one just after the edge that takes the last of these bytes. A new start strobe while a line is still open abandons that line and restarts the same row at byte 0.
- R3: Each accepted read (`rd_en_i`=1, `cmd_i`=0, `pkt_count_o`>0) shows on `rd_data_o` after the next edge. It returns the stored bytes in order of reception: byte 0 first, with packets in commit order.
- R4: A plain read of the last byte of a row moves the pointer to byte 0 of the next row and lowers `pkt_count_o` by one.
- R5: A read while `pkt_count_o` is 0 is ignored. The pointer does not move and `rd_data_o` holds its value.
- R6: `cmd_i`=2 (rewind) sets the pointer to byte 0 of the current packet and leaves `pkt_count_o` unchanged.
- R7: `cmd_i`=3 (skip) moves the pointer to byte 0 of the next packet and lowers `pkt_count_o` by one. It is ignored while `pkt_count_o` is 0.
- R8: `cmd_i`=1 (restart) sets the pointer to byte 0 of the first packet row. It sets `pkt_count_o` to the packet index of the next row to be written, with rows numbered from 0 at the first packet row.
- R9: A nonzero `cmd_i` takes priority over `rd_en_i` in the same cycle. No read is performed and `rd_data_o` holds its value.
- R10: A start strobe while `pkt_count_o` equals PKT_ROWS drops the whole line. None of its bytes are stored, and `drop_count_o` rises by one, saturating at all ones.
- R11: Write and read rows wrap from the last packet row to the first packet row. The control row is skipped.
- R12: A commit and a consume in the same cycle leave `pkt_count_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write byte valid |
| wr_start_i | input | 1 | Marks the first info byte of a line |
| wr_data_i | input | DW | Write byte |
| rd_en_i | input | 1 | Host read strobe |
| cmd_i | input | 2 | Pointer command: 0 none, 1 restart, 2 rewind, 3 skip |
| rd_data_o | output | DW | Read byte, valid the cycle after an accepted read |
| pkt_count_o | output | clog2(PKT_ROWS+1) | Committed packets not yet consumed |
| drop_count_o | output | DROP_W | Saturating count of dropped lines |

## Verification
The bench builds the block with ROW_BYTES=6, PKT_ROWS=3 and DROP_W=3. With these values a single line is only six writes, the packet region fills after three lines, and both pointers wrap within a handful of packets. The drop counter saturates after seven dropped lines. This brings the full condition, wrap-around, restart from a wrapped write index, and a commit that coincides with a consume within a short run. Each stored byte encodes its line tag and byte position, so every value read back shows which row and offset the pointer was at.

// File: rtl/vbi_pkt_buf_pkg.sv
package vbi_pkt_buf_pkg;
  typedef enum logic [1:0] {
    CMD_NONE    = 2'd0,
    CMD_RESTART = 2'd1,
    CMD_REWIND  = 2'd2,
    CMD_SKIP    = 2'd3
  } pb_cmd_e;
endpackage

// File: rtl/pb_ram.sv
module pb_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 2024,
  parameter int AW    = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;

  // R5
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_q));
endmodule

// File: rtl/pb_wr_ctrl.sv
module pb_wr_ctrl #(
  parameter int ROW_BYTES = 44,
  parameter int PKT_ROWS  = 45,
  parameter int DW        = 8,
  parameter int DROP_W    = 8,
  parameter int AW        = 11,
  parameter int RW        = 6,
  parameter int BW        = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              start_i,
  input  logic [DW-1:0]     data_i,
  input  logic              full_i,
  output logic              we_o,
  output logic [AW-1:0]     waddr_o,
  output logic [DW-1:0]     wdata_o,
  output logic              commit_o,
  output logic [RW-1:0]     wr_idx_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  logic              active_q;
  logic [BW-1:0]     wb_q;
  logic [RW-1:0]     idx_q;
  logic [DROP_W-1:0] drop_q;
  logic              take_start, take_body, drop_ev, last;
  logic [BW-1:0]     byte_sel;
  logic [RW-1:0]     idx_nxt;

  assign take_start = valid_i && start_i && !full_i;
  assign drop_ev    = valid_i && start_i && full_i;
  assign take_body  = valid_i && !start_i && active_q;
  assign last       = take_body && (wb_q == BW'(ROW_BYTES - 1));
  assign byte_sel   = take_start ? '0 : wb_q;
  assign idx_nxt    = (idx_q == RW'(PKT_ROWS - 1)) ? '0 : idx_q + RW'(1);

  // packet row n lives at RAM row n+1; row 0 is the control row
  assign waddr_o    = AW'((32'(idx_q) + 32'd1) * 32'(ROW_BYTES) + 32'(byte_sel));
  assign we_o       = take_start || take_body;
  assign wdata_o    = data_i;
  assign commit_o   = last;
  assign wr_idx_o   = idx_q;
  assign drop_cnt_o = drop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      wb_q     <= '0;
      idx_q    <= '0;
      drop_q   <= '0;
    end else if (drop_ev) begin
      active_q <= 1'b0;
      wb_q     <= '0;
      if (drop_q != '1) drop_q <= drop_q + DROP_W'(1);
    end else if (take_start) begin
      active_q <= 1'b1;
      wb_q     <= BW'(1);
    end else if (take_body) begin
      if (last) begin
        active_q <= 1'b0;
        wb_q     <= '0;
        idx_q    <= idx_nxt;
      end else begin
        wb_q <= wb_q + BW'(1);
      end
    end
  end

  // R10
  drop_only_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && start_i && full_i) |=> $stable(drop_q));
  // R10
  no_write_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i |-> !we_o);
endmodule

// File: rtl/pb_rd_ctrl.sv
module pb_rd_ctrl
  import vbi_pkt_buf_pkg::*;
#(
  parameter int ROW_BYTES = 44,
  parameter int PKT_ROWS  = 45,
  parameter int AW        = 11,
  parameter int RW        = 6,
  parameter int BW        = 6,
  parameter int CW        = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  pb_cmd_e       cmd_i,
  input  logic [CW-1:0] count_i,
  input  logic [RW-1:0] wr_idx_i,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  output logic          consume_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o
);
  logic [RW-1:0] idx_q, idx_nxt;
  logic [BW-1:0] rb_q;
  logic          has_pkt, fire, end_row;

  assign has_pkt    = (count_i != '0);
  assign fire       = rd_en_i && (cmd_i == CMD_NONE) && has_pkt;
  assign end_row    = (rb_q == BW'(ROW_BYTES - 1));
  assign idx_nxt    = (idx_q == RW'(PKT_ROWS - 1)) ? '0 : idx_q + RW'(1);
  assign consume_o  = ((cmd_i == CMD_SKIP) && has_pkt) || (fire && end_row);
  assign load_o     = (cmd_i == CMD_RESTART);
  assign load_val_o = CW'(wr_idx_i);
  assign re_o       = fire;
  assign raddr_o    = AW'((32'(idx_q) + 32'd1) * 32'(ROW_BYTES) + 32'(rb_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      rb_q  <= '0;
    end else begin
      unique case (cmd_i)
        CMD_RESTART: begin
          idx_q <= '0;
          rb_q  <= '0;
        end
        CMD_REWIND: rb_q <= '0;
        CMD_SKIP: if (has_pkt) begin
          idx_q <= idx_nxt;
          rb_q  <= '0;
        end
        default: if (fire) begin
          if (end_row) begin
            idx_q <= idx_nxt;
            rb_q  <= '0;
          end else begin
            rb_q <= rb_q + BW'(1);
          end
        end
      endcase
    end
  end

  // R7
  consume_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_o |-> count_i != '0);
  // R6
  rewind_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_REWIND) |=> $stable(idx_q));
endmodule

// File: rtl/vbi_pkt_buf.sv
module vbi_pkt_buf
  import vbi_pkt_buf_pkg::*;
#(
  parameter int ROW_BYTES = 44,
  parameter int PKT_ROWS  = 45,
  parameter int DW        = 8,
  parameter int DROP_W    = 8,
  localparam int DEPTH    = ROW_BYTES * (PKT_ROWS + 1),
  localparam int AW       = $clog2(DEPTH),
  localparam int RW       = (PKT_ROWS > 1) ? $clog2(PKT_ROWS) : 1,
  localparam int BW       = $clog2(ROW_BYTES),
  localparam int CW       = $clog2(PKT_ROWS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic              wr_start_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              rd_en_i,
  input  logic [1:0]        cmd_i,
  output logic [DW-1:0]     rd_data_o,
  output logic [CW-1:0]     pkt_count_o,
  output logic [DROP_W-1:0] drop_count_o
);
  logic          we, re, commit, consume, load, full;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] wdata;
  logic [RW-1:0] wr_idx;
  logic [CW-1:0] count_q, load_val;
  pb_cmd_e       cmd;

  assign cmd  = pb_cmd_e'(cmd_i);
  assign full = (count_q == CW'(PKT_ROWS));

  pb_wr_ctrl #(
    .ROW_BYTES(ROW_BYTES), .PKT_ROWS(PKT_ROWS), .DW(DW), .DROP_W(DROP_W),
    .AW(AW), .RW(RW), .BW(BW)
  ) u_wr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (wr_valid_i),
    .start_i   (wr_start_i),
    .data_i    (wr_data_i),
    .full_i    (full),
    .we_o      (we),
    .waddr_o   (waddr),
    .wdata_o   (wdata),
    .commit_o  (commit),
    .wr_idx_o  (wr_idx),
    .drop_cnt_o(drop_count_o)
  );

  pb_rd_ctrl #(
    .ROW_BYTES(ROW_BYTES), .PKT_ROWS(PKT_ROWS),
    .AW(AW), .RW(RW), .BW(BW), .CW(CW)
  ) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .cmd_i     (cmd),
    .count_i   (count_q),
    .wr_idx_i  (wr_idx),
    .re_o      (re),
    .raddr_o   (raddr),
    .consume_o (consume),
    .load_o    (load),
    .load_val_o(load_val)
  );

  pb_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .re_i   (re),
    .raddr_i(raddr),
    .rdata_o(rd_data_o)
  );

  // restart reloads the occupancy from the write index
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   count_q <= '0;
    else if (load) count_q <= load_val + CW'(commit);
    else           count_q <= count_q + CW'(commit) - CW'(consume);
  end

  assign pkt_count_o = count_q;

  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(PKT_ROWS));
  // R10
  commit_not_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> !full);
  // R12
  net_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && consume && !load) |=> $stable(count_q));
endmodule

// File: tb/vbi_pkt_buf_tb.sv
module vbi_pkt_buf_tb;
  localparam int ROW_BYTES = 6;
  localparam int PKT_ROWS  = 3;
  localparam int DROP_W    = 3;
  localparam int CW        = $clog2(PKT_ROWS + 1);

  localparam logic [1:0] OP_LINE = 2'd0;
  localparam logic [1:0] OP_RD   = 2'd1;
  localparam logic [1:0] OP_CMD  = 2'd2;
  localparam logic [7:0] C_RST = 8'd1, C_RWD = 8'd2, C_SKP = 8'd3, NA = 8'd0;
  localparam int NV = 33;

  // {op, arg, expected count, expected rd_data}; line tag T byte b stores {T,b}
  localparam logic [21:0] VEC [NV] = '{
    {OP_LINE, 8'h01, 4'd1, 8'h00},  // R2 line 1 -> row 0
    {OP_RD,   NA,    4'd1, 8'h10},  // R3
    {OP_RD,   NA,    4'd1, 8'h11},
    {OP_CMD,  C_RWD, 4'd1, 8'h11},  // R6
    {OP_RD,   NA,    4'd1, 8'h10},  // R6
    {OP_RD,   NA,    4'd1, 8'h11},
    {OP_RD,   NA,    4'd1, 8'h12},
    {OP_RD,   NA,    4'd1, 8'h13},
    {OP_RD,   NA,    4'd1, 8'h14},
    {OP_RD,   NA,    4'd0, 8'h15},  // R4 end of row consumes
    {OP_RD,   NA,    4'd0, 8'h15},  // R5 empty read ignored
    {OP_LINE, 8'h02, 4'd1, 8'h15},
    {OP_LINE, 8'h03, 4'd2, 8'h15},
    {OP_RD,   NA,    4'd2, 8'h20},
    {OP_CMD,  C_SKP, 4'd1, 8'h20},  // R7
    {OP_RD,   NA,    4'd1, 8'h30},  // R7
    {OP_LINE, 8'h04, 4'd2, 8'h30},  // R11 write wraps to row 0
    {OP_CMD,  C_SKP, 4'd1, 8'h30},  // R11 read wraps
    {OP_RD,   NA,    4'd1, 8'h40},
    {OP_CMD,  C_RST, 4'd1, 8'h40},  // R8 count = write index 1
    {OP_RD,   NA,    4'd1, 8'h40},  // R8
    {OP_LINE, 8'h05, 4'd2, 8'h40},
    {OP_LINE, 8'h06, 4'd3, 8'h40},
    {OP_LINE, 8'h07, 4'd3, 8'h40},  // R10 dropped
    {OP_CMD,  C_SKP, 4'd2, 8'h40},
    {OP_RD,   NA,    4'd2, 8'h50},
    {OP_CMD,  C_SKP, 4'd1, 8'h50},
    {OP_RD,   NA,    4'd1, 8'h60},
    {OP_CMD,  C_SKP, 4'd0, 8'h60},
    {OP_CMD,  C_SKP, 4'd0, 8'h60},  // R7 ignored when empty
    {OP_RD,   NA,    4'd0, 8'h60},  // R5
    {OP_LINE, 8'h08, 4'd1, 8'h60},
    {OP_RD,   NA,    4'd1, 8'h80}   // R7 pointer stayed on row 0
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_valid_i = 1'b0, wr_start_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0]        wr_data_i = '0;
  logic [1:0]        cmd_i = '0;
  logic [7:0]        rd_data_o;
  logic [CW-1:0]     pkt_count_o;
  logic [DROP_W-1:0] drop_count_o;
  int n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  vbi_pkt_buf #(.ROW_BYTES(ROW_BYTES), .PKT_ROWS(PKT_ROWS), .DW(8), .DROP_W(DROP_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_start_i(wr_start_i),
    .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .cmd_i(cmd_i), .rd_data_o(rd_data_o),
    .pkt_count_o(pkt_count_o), .drop_count_o(drop_count_o)
  );

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
    wr_valid_i = 1'b0; wr_start_i = 1'b0; rd_en_i = 1'b0; cmd_i = '0;
  endtask

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic wbyte(logic st, logic [7:0] d);
    wr_valid_i = 1'b1; wr_start_i = st; wr_data_i = d;
    tick();
  endtask

  task automatic write_line(logic [3:0] tag);
    for (int b = 0; b < ROW_BYTES; b++) wbyte(b == 0, {tag, 4'(b)});
  endtask

  task automatic rd1();
    rd_en_i = 1'b1;
    tick();
  endtask

  task automatic cmd1(logic [1:0] c);
    cmd_i = c;
    tick();
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 count", 8'(pkt_count_o), 8'd0);
    chk("R1 drop", 8'(drop_count_o), 8'd0);
    chk("R1 data", rd_data_o, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      case (v[21:20])
        OP_LINE: write_line(v[15:12]);
        OP_RD:   rd1();
        default: cmd1(v[13:12]);
      endcase
      chk($sformatf("R2-R11 table vec%0d count", i), 8'(pkt_count_o), 8'(v[11:8]));
      chk($sformatf("R3 table vec%0d data", i), rd_data_o, v[7:0]);
    end
    chk("R10 drop after one lost line", 8'(drop_count_o), 8'd1);

    do_reset();
    chk("R1 count after reset", 8'(pkt_count_o), 8'd0);
    chk("R1 drop after reset", 8'(drop_count_o), 8'd0);

    // R9: command wins over a read in the same cycle
    write_line(4'h9);
    write_line(4'hA);
    rd1();
    chk("R3 first byte", rd_data_o, 8'h90);
    rd_en_i = 1'b1; cmd_i = 2'd2;
    tick();
    chk("R9 no read with command", rd_data_o, 8'h90);
    chk("R9 count", 8'(pkt_count_o), 8'd2);
    rd1();
    chk("R9 rewind took effect", rd_data_o, 8'h90);

    // R12: commit and consume in one cycle
    for (int b = 1; b < ROW_BYTES - 1; b++) begin
      rd1();
      chk("R3 sequential byte", rd_data_o, {4'h9, 4'(b)});
    end
    for (int b = 0; b < ROW_BYTES - 1; b++) wbyte(b == 0, {4'hB, 4'(b)});
    rd_en_i = 1'b1;
    wr_valid_i = 1'b1; wr_start_i = 1'b0; wr_data_i = {4'hB, 4'(ROW_BYTES - 1)};
    tick();
    chk("R12 last byte read", rd_data_o, {4'h9, 4'(ROW_BYTES - 1)});
    chk("R12 count unchanged", 8'(pkt_count_o), 8'd2);

    // R8: restart from a wrapped write index
    cmd1(2'd1);
    chk("R8 count from write index", 8'(pkt_count_o), 8'd0);
    rd1();
    chk("R5 read ignored after restart", rd_data_o, {4'h9, 4'(ROW_BYTES - 1)});
    write_line(4'hC);
    rd1();
    chk("R8 pointer on first packet row", rd_data_o, 8'hC0);

    // R2: a new start abandons the open line
    wbyte(1'b1, 8'hD0);
    wbyte(1'b0, 8'hD1);
    wbyte(1'b0, 8'hD2);
    write_line(4'hE);
    chk("R2 one commit for restarted line", 8'(pkt_count_o), 8'd2);
    cmd1(2'd3);
    rd1();
    chk("R2 restarted row byte 0", rd_data_o, 8'hE0);
    rd1();
    chk("R2 restarted row byte 1", rd_data_o, 8'hE1);

    // R10: full drops lines, counter saturates
    write_line(4'hF);
    write_line(4'h7);
    chk("R10 full count", 8'(pkt_count_o), 8'(PKT_ROWS));
    write_line(4'h2);
    chk("R10 drop count 1", 8'(drop_count_o), 8'd1);
    for (int k = 0; k < 7; k++) write_line(4'h2);
    chk("R10 drop saturates", 8'(drop_count_o), 8'd7);
    chk("R10 count held", 8'(pkt_count_o), 8'(PKT_ROWS));
    cmd1(2'd3);
    rd1();
    chk("R10 row after skip", rd_data_o, 8'hF0);
    cmd1(2'd3);
    rd1();
    chk("R11 wrapped row not overwritten", rd_data_o, 8'h70);
    chk("R7 count after skips", 8'(pkt_count_o), 8'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule